// File: doc/BRIEF.md
# Compare-Match General-Purpose Timer

A memory-mapped timer with an up counter of `CNT_W` bits (32 by default), one compare channel, a sticky match flag and an interrupt request. Software programs it over a simple single-cycle register bus. Writes take effect on the clock edge where `sel_i` and `wr_i` are both high. Reads are combinational from `addr_i`.

The counter advances on a tick taken from one of three enable-pulse inputs. The pulses share the block's clock. A control field picks the source. The chosen pulse passes through a main prescaler. The oscillator source also passes through its own pre-divider first. When the counter lands on the compare value, the match flag is set. In free-run mode the counter then keeps counting and wraps. In restart mode it returns to zero on the next tick. The flag is cleared by writing one to it. The interrupt output is the flag masked by an enable bit.

Top module: `gpt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: The registers sit at these offsets: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, counter 0x24.
  - Control bits: bit 0 enable, bit 3 wait-enable, bits 8:6 source code, bit 9 free-run, bit 10 oscillator-path enable. All other control bits read 0.
  - Prescaler fields: the main divider is in bits 11:0 and the oscillator pre-divider in bits 15:12.
  - Interrupt enable is bit 0, and compare holds `CNT_W` bits. All of these read back as written.
- R3: Source code 1 counts `bus_tick_i`, code 2 counts `per_tick_i` and code 5 counts the oscillator path. Any other code produces no count. Pulses on unselected inputs have no effect on the counter.
- R4: With control bit 10 set, the oscillator path divides `osc_tick_i` by the pre-divider field plus 1. With bit 10 clear, it divides by a fixed 8.
- R5: The main prescaler divides the selected tick by its field plus 1, so a value of 0 passes every tick. Any write to the control or prescaler register restarts both division phases.
- R6: With the enable bit clear, the counter holds its value. Setting the bit again resumes counting from the held value.
- R7: The match flag is set on the tick that brings the counter equal to compare.
  - In free-run mode the counter keeps incrementing past the match and wraps modulo 2^`CNT_W`.
  - A compare value one behind the counter therefore matches only after a full wrap.
- R8: With free-run clear, the tick after a match reloads the counter to 0. The count then cycles with period compare+1.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a match occurs in the same cycle as a clear, the flag ends up set.
- R10: `irq_o` is high exactly while both the flag and interrupt-enable bit 0 are set. Clearing the enable masks the request without clearing the flag.
- R11: The counter register is read-only, and a write to offset 0x24 leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | Write qualifier for the access |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| bus_tick_i | input | 1 | Bus-clock tick enable pulse |
| per_tick_i | input | 1 | Peripheral-clock tick enable pulse |
| osc_tick_i | input | 1 | Oscillator tick enable pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that the tick inputs are single-cycle enable pulses in the block's own clock domain. They also assume that a bus access lasts exactly one cycle with a stable address.

The stimulus follows both rules. Every tick and every bus write is a one-cycle pulse, applied at the falling edge and withdrawn after the next rising edge. Pulses on unselected sources are applied in cycles separate from those on the selected source.

The bench uses an 8-bit counter. This makes full wraps, compare values behind the counter and restart periods short enough to sweep completely.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int DATA_W   = 32;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_PRE  = 'h04;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_IE   = 'h0C;
  localparam int OFF_CMP  = 'h10;
  localparam int OFF_CNT  = 'h24;

  localparam logic [2:0] SRC_BUS = 3'd1;
  localparam logic [2:0] SRC_PER = 3'd2;
  localparam logic [2:0] SRC_OSC = 3'd5;

  localparam int OSC_FIXED_DIV = 7;  // divide by 8 when the pre-divider is bypassed

  typedef struct packed {
    logic       osc_en;
    logic       frr;
    logic [2:0] src;
    logic       wait_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int OSC_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                flag_i,
  output ctrl_t               ctrl_o,
  output logic [PRE_W-1:0]    pre_o,
  output logic [OSC_W-1:0]    osc_div_o,
  output logic                ie_o,
  output logic [CNT_W-1:0]    cmp_o,
  output logic                clr_o,
  output logic                restart_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int PS_W = PRE_W + OSC_W;

  logic we;
  logic wr_ctrl, wr_pre, wr_stat, wr_ie, wr_cmp;

  assign we      = sel_i & wr_i;
  assign wr_ctrl = we && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_pre  = we && (addr_i == ADDR_W'(OFF_PRE));
  assign wr_stat = we && (addr_i == ADDR_W'(OFF_STAT));
  assign wr_ie   = we && (addr_i == ADDR_W'(OFF_IE));
  assign wr_cmp  = we && (addr_i == ADDR_W'(OFF_CMP));

  assign clr_o     = wr_stat & wdata_i[0];
  assign restart_o = wr_ctrl | wr_pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      pre_o     <= '0;
      osc_div_o <= '0;
      ie_o      <= 1'b0;
      cmp_o     <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_o.en      <= wdata_i[0];
        ctrl_o.wait_en <= wdata_i[3];
        ctrl_o.src     <= wdata_i[8:6];
        ctrl_o.frr     <= wdata_i[9];
        ctrl_o.osc_en  <= wdata_i[10];
      end
      if (wr_pre) begin
        pre_o     <= wdata_i[PRE_W-1:0];
        osc_div_o <= wdata_i[PS_W-1:PRE_W];
      end
      if (wr_ie)  ie_o  <= wdata_i[0];
      if (wr_cmp) cmp_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL): rdata_o = {21'd0, ctrl_o.osc_en, ctrl_o.frr, ctrl_o.src,
                                    2'd0, ctrl_o.wait_en, 2'd0, ctrl_o.en};
      ADDR_W'(OFF_PRE):  rdata_o = DATA_W'({osc_div_o, pre_o});
      ADDR_W'(OFF_STAT): rdata_o = DATA_W'(flag_i);
      ADDR_W'(OFF_IE):   rdata_o = DATA_W'(ie_o);
      ADDR_W'(OFF_CMP):  rdata_o = DATA_W'(cmp_o);
      ADDR_W'(OFF_CNT):  rdata_o = DATA_W'(cnt_i);
      default:           rdata_o = '0;
    endcase
  end

  assert_cmp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cmp |=> $stable(cmp_o));
  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_o));
endmodule

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen
  import gpt_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int OSC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [2:0]       src_i,
  input  logic             osc_en_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [OSC_W-1:0] osc_div_i,
  input  logic             bus_tick_i,
  input  logic             per_tick_i,
  input  logic             osc_tick_i,
  output logic             tick_o
);
  logic [OSC_W-1:0] osc_cnt, osc_lim;
  logic [PRE_W-1:0] pre_cnt;
  logic             osc_pulse, sel_tick;

  assign osc_lim   = osc_en_i ? osc_div_i : OSC_W'(OSC_FIXED_DIV);
  assign osc_pulse = en_i & osc_tick_i & (osc_cnt >= osc_lim);

  always_comb begin
    case (src_i)
      SRC_BUS: sel_tick = bus_tick_i;
      SRC_PER: sel_tick = per_tick_i;
      SRC_OSC: sel_tick = osc_pulse;
      default: sel_tick = 1'b0;
    endcase
  end

  assign tick_o = en_i & sel_tick & (pre_cnt >= pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_cnt <= '0;
      pre_cnt <= '0;
    end else if (restart_i) begin
      osc_cnt <= '0;
      pre_cnt <= '0;
    end else if (en_i) begin
      if (osc_tick_i) osc_cnt <= (osc_cnt >= osc_lim) ? '0 : osc_cnt + 1'b1;
      if (sel_tick)   pre_cnt <= (pre_cnt >= pre_i)   ? '0 : pre_cnt + 1'b1;
    end
  end

  assert_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (bus_tick_i || per_tick_i || osc_tick_i));
  assert_pre_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && pre_i != '0) |=> (!tick_o || pre_i == '0));
  assert_osc_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_pulse && osc_lim != '0) |=> (!osc_pulse || osc_lim == '0));
endmodule

// File: rtl/gpt_core.sv
module gpt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             frr_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;

  assign cnt_nxt = (!frr_i && cnt_o == cmp_i) ? '0 : cnt_o + 1'b1;
  assign hit     = tick_i && (cnt_nxt == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (tick_i) cnt_o <= cnt_nxt;
      flag_o <= hit | (flag_o & ~clr_i);  // set beats clear
    end
  end

  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !frr_i && cnt_o == cmp_i) |=> (cnt_o == '0));
  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_match_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_nxt == cmp_i) |=> flag_o);
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int OSC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              bus_tick_i,
  input  logic              per_tick_i,
  input  logic              osc_tick_i,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [PRE_W-1:0] pre;
  logic [OSC_W-1:0] osc_div;
  logic             ie, clr, restart, tick, flag;
  logic [CNT_W-1:0] cmp, cnt;

  gpt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .OSC_W(OSC_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .flag_i(flag), .ctrl_o(ctrl), .pre_o(pre), .osc_div_o(osc_div),
    .ie_o(ie), .cmp_o(cmp), .clr_o(clr), .restart_o(restart), .rdata_o
  );

  gpt_tick_gen #(.PRE_W(PRE_W), .OSC_W(OSC_W)) u_tick (
    .clk_i, .rst_ni, .en_i(ctrl.en), .restart_i(restart), .src_i(ctrl.src),
    .osc_en_i(ctrl.osc_en), .pre_i(pre), .osc_div_i(osc_div),
    .bus_tick_i, .per_tick_i, .osc_tick_i, .tick_o(tick)
  );

  gpt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .frr_i(ctrl.frr), .cmp_i(cmp),
    .clr_i(clr), .cnt_o(cnt), .flag_o(flag)
  );

  assign irq_o = flag & ie;

  assert_enable_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> $stable(cnt));
  assert_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(sel_i && wr_i && (addr_i == ADDR_W'(OFF_STAT) ||
                                  addr_i == ADDR_W'(OFF_IE)))) |=> irq_o);
endmodule

// File: tb/sim_gpt_timer.sv
module sim_gpt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int WDOG = 150000;
  localparam logic [5:0] A_CTRL = 6'h00, A_PRE = 6'h04, A_STAT = 6'h08,
                         A_IE = 6'h0C, A_CMP = 6'h10, A_CNT = 6'h24;
  localparam logic [31:0] EN = 32'h1, FRR = 32'h200, OSCEN = 32'h400;

  logic clk = 0, rst_n = 0, sel = 0, wr = 0, bt = 0, pt = 0, ot = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int vectors = 0, fails = 0;

  gpt_timer #(.ADDR_W(6), .CNT_W(CW), .PRE_W(12), .OSC_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .bus_tick_i(bt), .per_tick_i(pt),
    .osc_tick_i(ot), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=running exp=done");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [5:0] a, input logic [31:0] d,
                     input logic b, input logic p, input logic o);
    @(negedge clk);
    sel = w; wr = w; addr = a; wdata = d; bt = b; pt = p; ot = o;
    @(posedge clk);
    #1 sel = 0; wr = 0; bt = 0; pt = 0; ot = 0;
  endtask

  task automatic wrr(input logic [5:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick_on(input int s);
    cyc(0, 6'h3F, 0, s == 1, s == 2, s == 5);
  endtask

  task automatic tick_off(input int s);
    cyc(0, 6'h3F, 0, s != 1, s != 2, s != 5);
  endtask

  logic [31:0] v, c0, c1, cmpv;
  int k;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    foreach (A_CTRL[i]) ;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_PRE, v);  chk("R1 pre", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_IE, v);   chk("R1 ie", v, 0);
    rd(A_CMP, v);  chk("R1 cmp", v, 0);
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    chk("R1 irq", irq, 0);

    // R2 readback masks
    wrr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R2 ctrl", v, 32'h7C9);
    wrr(A_PRE, 32'hFFFF_FFFF);  rd(A_PRE, v);  chk("R2 pre", v, 32'hFFFF);
    wrr(A_IE, 32'hFFFF_FFFF);   rd(A_IE, v);   chk("R2 ie", v, 1);
    wrr(A_CMP, 32'hFFFF_FFFF);  rd(A_CMP, v);  chk("R2 cmp", v, 32'hFF);
    wrr(A_CTRL, 0); wrr(A_PRE, 0); wrr(A_IE, 0);

    // R3 R5 bus and peripheral sources, prescaler sweep
    for (int s = 1; s <= 2; s++)
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 10; n++) begin
          wrr(A_CTRL, 0); wrr(A_PRE, p);
          rd(A_CNT, c0);
          wrr(A_CTRL, EN | FRR | (s << 6));
          for (int j = 0; j < n; j++) begin tick_on(s); tick_off(s); end
          rd(A_CNT, c1);
          chk($sformatf("R3/R5 src%0d pre%0d n%0d", s, p, n), (c1 - c0) & 8'hFF, n / (p + 1));
        end

    // R3 unused source codes
    foreach (c0[i]) ;
    for (int code = 0; code < 8; code++) begin
      if (code == 1 || code == 2 || code == 5) continue;
      rd(A_CNT, c0);
      wrr(A_CTRL, EN | FRR | OSCEN | (code << 6));
      for (int j = 0; j < 6; j++) cyc(0, 6'h3F, 0, 1, 1, 1);
      rd(A_CNT, c1);
      chk($sformatf("R3 code%0d", code), c1, c0);
    end

    // R4 oscillator path
    for (int oe = 0; oe < 2; oe++)
      for (int d = 0; d < 4; d++)
        for (int p = 0; p < 2; p++)
          for (int n = 0; n < 20; n += 3) begin
            int dv;
            dv = oe ? d + 1 : 8;
            wrr(A_CTRL, 0); wrr(A_PRE, (d << 12) | p);
            rd(A_CNT, c0);
            wrr(A_CTRL, EN | FRR | (5 << 6) | (oe ? OSCEN : 0));
            for (int j = 0; j < n; j++) begin tick_on(5); tick_off(5); end
            rd(A_CNT, c1);
            chk($sformatf("R4 oe%0d d%0d p%0d n%0d", oe, d, p, n),
                (c1 - c0) & 8'hFF, (n / dv) / (p + 1));
          end

    // R6 enable hold and resume
    wrr(A_PRE, 0); wrr(A_CTRL, EN | FRR | (1 << 6));
    rd(A_CNT, c0);
    repeat (5) tick_on(1);
    rd(A_CNT, v); chk("R6 run", v, (c0 + 5) & 8'hFF);
    wrr(A_CTRL, FRR | (1 << 6));
    repeat (5) tick_on(1);
    rd(A_CNT, v); chk("R6 hold", v, (c0 + 5) & 8'hFF);
    wrr(A_CTRL, EN | FRR | (1 << 6));
    repeat (3) tick_on(1);
    rd(A_CNT, v); chk("R6 resume", v, (c0 + 8) & 8'hFF);

    // R7 free-run match, continue, wrap
    rd(A_CNT, c0);
    cmpv = (c0 + 5) & 8'hFF;
    wrr(A_CMP, cmpv); wrr(A_STAT, 1);
    repeat (4) tick_on(1);
    rd(A_STAT, v); chk("R7 before match", v, 0);
    tick_on(1);
    rd(A_STAT, v); chk("R7 match flag", v, 1);
    rd(A_CNT, v);  chk("R7 match cnt", v, cmpv);
    tick_on(1);
    rd(A_CNT, v);  chk("R7 continues", v, (cmpv + 1) & 8'hFF);
    wrr(A_STAT, 1);
    repeat (254) tick_on(1);
    rd(A_STAT, v); chk("R7 behind no early", v, 0);
    tick_on(1);
    rd(A_STAT, v); chk("R7 behind after wrap", v, 1);
    rd(A_CNT, v);  chk("R7 wrap cnt", v, cmpv);

    // R8 restart mode
    wrr(A_CMP, 4); wrr(A_CTRL, EN | (1 << 6));
    rd(A_CNT, c0);
    k = (4 - c0) & 8'hFF;
    wrr(A_STAT, 1);
    repeat (k) tick_on(1);
    rd(A_CNT, v); chk("R8 reach cmp", v, 4);
    if (k > 0) begin rd(A_STAT, v); chk("R8 flag", v, 1); end
    tick_on(1);
    rd(A_CNT, v); chk("R8 reload", v, 0);
    for (int i = 1; i <= 12; i++) begin
      tick_on(1);
      rd(A_CNT, v); chk($sformatf("R8 period i%0d", i), v, i % 5);
    end

    // R9 write-one-to-clear, set priority
    wrr(A_STAT, 0);
    rd(A_STAT, v); chk("R9 write0 keeps", v, 1);
    wrr(A_STAT, 1);
    rd(A_STAT, v); chk("R9 write1 clears", v, 0);
    tick_on(1);                       // cnt 2 -> 3
    cyc(1, A_STAT, 1, 1, 0, 0);       // clear with match (3 -> 4)
    rd(A_STAT, v); chk("R9 set wins", v, 1);
    rd(A_CNT, v);  chk("R9 cnt at cmp", v, 4);

    // R10 interrupt gating
    wrr(A_IE, 0);
    chk("R10 masked irq", irq, 0);
    rd(A_STAT, v); chk("R10 mask keeps flag", v, 1);
    wrr(A_IE, 1);
    chk("R10 irq on", irq, 1);
    repeat (3) tick_on(1);
    chk("R10 irq held", irq, 1);
    wrr(A_STAT, 1);
    chk("R10 irq cleared", irq, 0);

    // R11 counter read-only
    rd(A_CNT, c0);
    wrr(A_CNT, ~c0);
    rd(A_CNT, v); chk("R11 cnt unchanged", v, c0);

    summary();
    $finish;
  end
endmodule